// File: doc/BRIEF.md
# Incremental Sigma-Delta Reconstruction Filter

This block is the digital back end of a third-order, single-bit incremental sigma-delta converter with a residue-refinement path. A start pulse opens a conversion. On each of the next N clock cycles the block takes one modulator bit, maps it to +1 or -1, and feeds it into a cascade of three delayed accumulators. The stage outputs are weighted by three coefficients and summed, and the sum is scaled by an overall gain. The result matches the loop's feedback path to its last integrator.

On the cycle after the N-th bit, the block samples a signed code from a secondary Nyquist converter that digitised the last-integrator residue. It weights that code by the secondary gain and adds it to the filter result, which cancels the modulator's quantisation error. The combined value is multiplied by a scale factor and rounded once. The block then emits one sample with a one-cycle strobe and clears itself for the next multiplexed channel. The secondary path width is chosen at elaboration: disabled, single-bit or multibit.

Top module: `isd_recon_filter`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: Each accepted modulator bit maps to +1 (bit 1) or -1 (bit 0). With stage values s1, s2, s3 starting from 0, every bit updates them at once as s1' = s1 + x, s2' = s2 + s1, s3' = s3 + s2, using the values before the update.
- R3: After the N-th bit, the filter value is F = k*(alpha*s1 + beta*s2 + gamma*s3). All coefficients are signed two's complement, and the products are kept at full precision.
- R4: `res_code` is sampled only on the clock edge one cycle after the edge that takes the N-th bit. Its value on any other cycle has no effect on the output.
- R5: The residue term is added to F as E shifted left by RES_SHIFT. With RES_BITS >= 2, E is `res_code` read as signed two's complement (gain 1). With RES_BITS = 1, E is +2 for code 1 and -2 for code 0. With RES_BITS = 0, E is 0.
- R6: `out_data` = floor((C*g + 2^(OUT_SHIFT-1)) / 2^OUT_SHIFT), where C is F plus the residue term. This rounds half toward +infinity, and the value is kept in OUT_W bits.
- R7: If start is sampled at clock edge E0, `out_valid` is 1 for exactly one cycle, after edge E0+N+2. Outside that cycle it is 0, and `out_data` changes only when `out_valid` rises.
- R8: A start pulse seen while a conversion is in progress (after acceptance, up to and including the edge that produces the result) is ignored. The running conversion's timing and value are unchanged.
- R9: Each conversion starts from cleared stages, so a result does not depend on any earlier conversion.
- R10: A synchronous reset during a conversion aborts it. No `out_valid` follows until a new start.
- R11: N is taken from `conv_len` at run time and may be any value from 1 to 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion (accepted when idle) |
| mod_bit | input | 1 | Modulator output bit |
| res_code | input | max(RES_BITS,1) | Secondary converter residue code |
| conv_len | input | CNT_W | Bits per conversion N (static during a conversion) |
| coef_alpha | input | COEF_W | Weight of first stage, signed |
| coef_beta | input | COEF_W | Weight of second stage, signed |
| coef_gamma | input | COEF_W | Weight of third stage, signed |
| coef_k | input | COEF_W | Overall filter gain, signed |
| coef_g | input | COEF_W | Output scale factor, signed |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W | Rounded, scaled result, signed |

## Verification
The assertions watch four things on every cycle. The strobe must come exactly N+2 edges after an accepted start and last one cycle. The output word must hold still between strobes. A start seen mid-run must leave the bit counter advancing. The first stage must never grow larger in magnitude than the number of bits consumed. The arithmetic is shown only by the bench's scenarios: cascade values under different bit patterns, the residue gain of each variant, half-way rounding, run-time lengths from 1 to 127, and the fact that residue codes outside the sampling edge are ignored. The bench scenarios also show the clearing between conversions and the recovery after an aborting reset.

// File: rtl/isd_recon_pkg.sv
package isd_recon_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_RES  = 2'd2,
      ST_OUT  = 2'd3
   } isd_state_t;

   localparam int unsigned FILTER_ORDER = 3;
endpackage

// File: rtl/isd_seq.sv
// Conversion sequencer: idle -> N bit cycles -> residue capture -> emit.
module isd_seq
   import isd_recon_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] conv_len,
   output isd_state_t       st_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             take_bit_o,
   output logic             take_res_o,
   output logic             emit_o,
   output logic             clear_o
);
   isd_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               st_q  <= ST_RUN;
               cnt_q <= '0;
            end
            ST_RUN: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == conv_len - 1'b1) st_q <= ST_RES;
            end
            ST_RES:  st_q <= ST_OUT;
            ST_OUT:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign st_o       = st_q;
   assign cnt_o      = cnt_q;
   assign take_bit_o = (st_q == ST_RUN);
   assign take_res_o = (st_q == ST_RES);
   assign emit_o     = (st_q == ST_OUT);
   assign clear_o    = ((st_q == ST_IDLE) && start) || (st_q == ST_OUT);
endmodule

// File: rtl/isd_integ.sv
// Cascade of delayed accumulators; stage 0 integrates the +/-1 bit.
module isd_integ
   import isd_recon_pkg::*;
#(
   parameter int ACC_W = 24,
   parameter int ORDER = FILTER_ORDER
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clear,
   input  logic                    en,
   input  logic                    bit_i,
   output logic signed [ACC_W-1:0] acc_o [ORDER]
);
   for (genvar i = 0; i < ORDER; i++) begin : g_stage
      logic signed [ACC_W-1:0] din;
      logic signed [ACC_W-1:0] q;

      if (i == 0) begin : g_head
         assign din = bit_i ? {{(ACC_W-1){1'b0}}, 1'b1} : {ACC_W{1'b1}};
      end else begin : g_tail
         assign din = acc_o[i-1];
      end

      always_ff @(posedge clk) begin
         if (rst || clear) q <= '0;
         else if (en)      q <= q + din;
      end

      assign acc_o[i] = q;
   end
endmodule

// File: rtl/isd_merge.sv
// Weighting, residue merge, scaling and single rounding.
module isd_merge #(
   parameter int ACC_W     = 24,
   parameter int COEF_W    = 12,
   parameter int RES_BITS  = 6,
   parameter int RES_SHIFT = 4,
   parameter int OUT_SHIFT = 8,
   parameter int OUT_W     = 24,
   localparam int RES_PW   = (RES_BITS == 0) ? 1 : RES_BITS
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     take_res,
   input  logic                     emit,
   input  logic signed [ACC_W-1:0]  acc_i [3],
   input  logic [RES_PW-1:0]        res_code,
   input  logic signed [COEF_W-1:0] coef_alpha,
   input  logic signed [COEF_W-1:0] coef_beta,
   input  logic signed [COEF_W-1:0] coef_gamma,
   input  logic signed [COEF_W-1:0] coef_k,
   input  logic signed [COEF_W-1:0] coef_g,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  out_data
);
   localparam int PW = ACC_W + COEF_W;
   localparam int SW = PW + 2;
   localparam int FW = SW + COEF_W;
   localparam int CW = FW + 1;
   localparam int MW = CW + COEF_W;

   logic signed [PW-1:0] pa, pb, pc;
   logic signed [SW-1:0] wsum;
   logic signed [FW-1:0] filt;
   logic signed [CW-1:0] res_term, comb_d, sum_q;
   logic signed [MW-1:0] prod, rnd, shifted;

   always_comb begin
      pa   = PW'(acc_i[0]) * PW'(coef_alpha);
      pb   = PW'(acc_i[1]) * PW'(coef_beta);
      pc   = PW'(acc_i[2]) * PW'(coef_gamma);
      wsum = SW'(pa) + SW'(pb) + SW'(pc);
      filt = FW'(wsum) * FW'(coef_k);
      comb_d = CW'(filt) + res_term;
   end

   if (RES_BITS == 0) begin : g_res_off
      logic res_unused;
      assign res_unused = res_code[0];
      assign res_term   = '0;
   end else if (RES_BITS == 1) begin : g_res_one
      assign res_term = res_code[0] ? (CW'(2) <<< RES_SHIFT)
                                    : -(CW'(2) <<< RES_SHIFT);
   end else begin : g_res_multi
      assign res_term = CW'(signed'(res_code)) <<< RES_SHIFT;
   end

   always_comb begin
      prod    = MW'(sum_q) * MW'(coef_g);
      rnd     = prod + (MW'(1) <<< (OUT_SHIFT - 1));
      shifted = rnd >>> OUT_SHIFT;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q     <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= emit;
         if (take_res) sum_q    <= comb_d;
         if (emit)     out_data <= OUT_W'(shifted);
      end
   end
endmodule

// File: rtl/isd_recon_filter.sv
module isd_recon_filter
   import isd_recon_pkg::*;
#(
   parameter int CNT_W     = 7,
   parameter int ACC_W     = 24,
   parameter int COEF_W    = 12,
   parameter int RES_BITS  = 6,
   parameter int RES_SHIFT = 4,
   parameter int OUT_SHIFT = 8,
   parameter int OUT_W     = 24,
   localparam int RES_PW   = (RES_BITS == 0) ? 1 : RES_BITS
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic                     mod_bit,
   input  logic [RES_PW-1:0]        res_code,
   input  logic [CNT_W-1:0]         conv_len,
   input  logic signed [COEF_W-1:0] coef_alpha,
   input  logic signed [COEF_W-1:0] coef_beta,
   input  logic signed [COEF_W-1:0] coef_gamma,
   input  logic signed [COEF_W-1:0] coef_k,
   input  logic signed [COEF_W-1:0] coef_g,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  out_data
);
   initial begin
      assert (RES_BITS >= 0 && RES_BITS <= 10) else $error("RES_BITS out of range");
      assert (CNT_W >= 2) else $error("CNT_W too small");
      assert (ACC_W >= 3 * CNT_W) else $error("ACC_W cannot hold third-order sum");
      assert (OUT_SHIFT >= 1) else $error("OUT_SHIFT must be at least 1");
   end

   isd_state_t              st_w;
   logic [CNT_W-1:0]        cnt_w;
   logic                    take_bit_w, take_res_w, emit_w, clear_w, busy_w;
   logic signed [ACC_W-1:0] acc_w [FILTER_ORDER];

   assign busy_w = (st_w != ST_IDLE);

   isd_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst(rst), .start(start), .conv_len(conv_len),
      .st_o(st_w), .cnt_o(cnt_w), .take_bit_o(take_bit_w),
      .take_res_o(take_res_w), .emit_o(emit_w), .clear_o(clear_w)
   );

   isd_integ #(.ACC_W(ACC_W), .ORDER(FILTER_ORDER)) u_integ (
      .clk(clk), .rst(rst), .clear(clear_w), .en(take_bit_w),
      .bit_i(mod_bit), .acc_o(acc_w)
   );

   isd_merge #(
      .ACC_W(ACC_W), .COEF_W(COEF_W), .RES_BITS(RES_BITS),
      .RES_SHIFT(RES_SHIFT), .OUT_SHIFT(OUT_SHIFT), .OUT_W(OUT_W)
   ) u_merge (
      .clk(clk), .rst(rst), .take_res(take_res_w), .emit(emit_w),
      .acc_i(acc_w), .res_code(res_code),
      .coef_alpha(coef_alpha), .coef_beta(coef_beta), .coef_gamma(coef_gamma),
      .coef_k(coef_k), .coef_g(coef_g),
      .out_valid(out_valid), .out_data(out_data)
   );
endmodule

// File: rtl/isd_recon_filter_chk.sv
module isd_recon_filter_chk
   import isd_recon_pkg::*;
#(
   parameter int CNT_W = 7,
   parameter int ACC_W = 24,
   parameter int OUT_W = 24
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    start,
   input logic [CNT_W-1:0]        conv_len,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] out_data,
   input logic                    busy,
   input isd_state_t              st,
   input logic [CNT_W-1:0]        bit_cnt,
   input logic signed [ACC_W-1:0] acc1
);
   logic             running;
   logic [CNT_W+1:0] run_cnt;
   logic [ACC_W-1:0] acc_abs;

   always_ff @(posedge clk) begin
      if (rst) begin
         running <= 1'b0;
         run_cnt <= '0;
      end else if (!busy && start) begin
         running <= 1'b1;
         run_cnt <= '0;
      end else if (out_valid) begin
         running <= 1'b0;
      end else if (running) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   always_comb acc_abs = acc1[ACC_W-1] ? ACC_W'(-acc1) : ACC_W'(acc1);

   AST_STROBE_TIMING: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (running && run_cnt == (CNT_W+2)'(conv_len) + 2'd2)); // R7
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid); // R7
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(rst)) |-> $stable(out_data)); // R7
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_data == '0)); // R1
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (st == ST_RUN && start && bit_cnt != conv_len - 1'b1)
      |=> (st == ST_RUN && bit_cnt == $past(bit_cnt) + 1'b1)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (running && busy) |-> (32'(acc_abs) <= 32'(run_cnt))); // R2
endmodule

bind isd_recon_filter isd_recon_filter_chk #(
   .CNT_W(CNT_W), .ACC_W(ACC_W), .OUT_W(OUT_W)
) u_chk (
   .clk(clk), .rst(rst), .start(start), .conv_len(conv_len),
   .out_valid(out_valid), .out_data(out_data), .busy(busy_w),
   .st(st_w), .bit_cnt(cnt_w), .acc1(acc_w[0])
);

// File: tb/isd_recon_filter_tb_top.sv
`timescale 1ns/1ps
module isd_recon_filter_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst = 1'b1;
   logic              start = 1'b0;
   logic              mod_bit = 1'b0;
   logic [5:0]        res6 = '0;
   logic [0:0]        res1 = '0;
   logic [0:0]        res0 = '0;
   logic [6:0]        conv_len = 7'd25;
   logic signed [11:0] c_al = 12'sd3, c_be = -12'sd2, c_ga = 12'sd1;
   logic signed [11:0] c_k = 12'sd5, c_g = 12'sd700;
   logic              v6, v1, v0;
   logic signed [23:0] d6, d1, d0;

   isd_recon_filter #(.RES_BITS(6)) dut_i (
      .clk(clk), .rst(rst), .start(start), .mod_bit(mod_bit), .res_code(res6),
      .conv_len(conv_len), .coef_alpha(c_al), .coef_beta(c_be), .coef_gamma(c_ga),
      .coef_k(c_k), .coef_g(c_g), .out_valid(v6), .out_data(d6));
   isd_recon_filter #(.RES_BITS(1)) dut_s1_i (
      .clk(clk), .rst(rst), .start(start), .mod_bit(mod_bit), .res_code(res1),
      .conv_len(conv_len), .coef_alpha(c_al), .coef_beta(c_be), .coef_gamma(c_ga),
      .coef_k(c_k), .coef_g(c_g), .out_valid(v1), .out_data(d1));
   isd_recon_filter #(.RES_BITS(0)) dut_s0_i (
      .clk(clk), .rst(rst), .start(start), .mod_bit(mod_bit), .res_code(res0),
      .conv_len(conv_len), .coef_alpha(c_al), .coef_beta(c_be), .coef_gamma(c_ga),
      .coef_k(c_k), .coef_g(c_g), .out_valid(v0), .out_data(d0));

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit pbit(input int pat, input int i);
      case (pat)
         0: return 1'b1;
         1: return 1'b0;
         2: return i[0];
         default: return ((i * 7 + 3) % 5) < 2;
      endcase
   endfunction

   function automatic longint q24(input longint c);
      logic signed [23:0] t;
      longint p;
      p = (c * longint'(c_g) + (64'sd1 <<< 7)) >>> 8;
      t = p[23:0];
      return longint'(t);
   endfunction

   // One conversion on all three variants; ign_at selects a cycle for a stray start.
   task automatic run_conv(input int n, input int pat, input int r6, input bit r1,
                           input int ign_at, input string tag);
      longint s1 = 0, s2 = 0, s3 = 0, f, x;
      conv_len = 7'(n);
      @(negedge clk); start = 1'b1; mod_bit = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = (i == ign_at);
         mod_bit = pbit(pat, i);
         x = mod_bit ? 1 : -1;
         s3 = s3 + s2; s2 = s2 + s1; s1 = s1 + x;
      end
      @(negedge clk);
      start = (ign_at == n);
      res6 = r6[5:0]; res1 = r1; res0 = ~r1; mod_bit = ~mod_bit;
      f = longint'(c_k) * (longint'(c_al) * s1 + longint'(c_be) * s2 + longint'(c_ga) * s3);
      @(negedge clk);
      start = 1'b0;
      res6 = ~res6; res1 = ~res1; res0 = ~res0; // R4: codes after the window
      chk({tag, " R7 early strobe"}, longint'(v6 | v1 | v0), 0);
      @(negedge clk);
      chk({tag, " R7 strobe"}, longint'({v6, v1, v0}), 7);
      chk({tag, " R3 R5 multibit"}, longint'(d6), q24(f + (longint'(r6) <<< 4)));
      chk({tag, " R5 single-bit"}, longint'(d1), q24(f + ((r1 ? 2 : -2) <<< 4)));
      chk({tag, " R5 disabled"}, longint'(d0), q24(f));
      @(negedge clk);
      chk({tag, " R7 single cycle"}, longint'(v6 | v1 | v0), 0);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", longint'(v6), 0);
      chk("R1 data in reset", longint'(d6), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 valid after reset", longint'(v6 | v1 | v0), 0);
   endtask

   task automatic t_patterns();
      run_conv(25, 0, 5,   1'b1, -1, "R2 ones");
      run_conv(25, 1, -7,  1'b0, -1, "R2 zeros");
      run_conv(31, 2, 31,  1'b1, -1, "R2 alternating");
      run_conv(39, 3, -32, 1'b0, -1, "R2 mixed");
   endtask

   task automatic t_lengths();
      run_conv(1,   0, 0,  1'b1, -1, "R11 N=1");
      run_conv(48,  3, 12, 1'b0, -1, "R11 N=48");
      run_conv(61,  2, -1, 1'b1, -1, "R11 N=61");
      run_conv(127, 0, 3,  1'b0, -1, "R11 N=127");
   endtask

   task automatic t_start_ignored();
      run_conv(25, 3, 9,  1'b1, 10, "R8 start mid-run");
      run_conv(25, 2, -4, 1'b0, 25, "R8 start at residue");
   endtask

   task automatic t_rounding();
      c_al = 12'sd1; c_be = 12'sd0; c_ga = 12'sd0; c_k = 12'sd1; c_g = 12'sd128;
      // C = 1 with no residue: (128 + 128) >> 8 = 1
      run_conv(1, 0, 0, 1'b1, -1, "R6 half up positive");
      c_g = -12'sd128;
      // C = 1 -> (-128 + 128) >> 8 = 0 ; with residue: (-(1+16)*128 + 128) >> 8 = -8
      run_conv(1, 0, 1, 1'b1, -1, "R6 half up negative");
      c_al = 12'sd3; c_be = -12'sd2; c_ga = 12'sd1; c_k = 12'sd5; c_g = -12'sd900;
      run_conv(31, 3, -20, 1'b0, -1, "R6 negative scale");
      c_g = 12'sd700;
   endtask

   task automatic t_abort();
      int seen = 0;
      conv_len = 7'd25;
      @(negedge clk); start = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); start = 1'b0; mod_bit = 1'b1;
      end
      rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (v6 | v1 | v0) seen++;
      end
      chk("R10 no strobe after abort", longint'(seen), 0);
      run_conv(25, 3, 2, 1'b1, -1, "R9 clean after abort");
      run_conv(25, 0, 2, 1'b1, -1, "R9 back-to-back");
   endtask

   initial begin
      t_reset();
      t_patterns();
      t_lengths();
      t_start_ignored();
      t_rounding();
      t_abort();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule